// File: doc/BRIEF.md
# JTAG Route Controller Bring-Up Sequencer

This block is a JTAG host that programs a route controller with a 6-bit instruction register so that a secondary TAP joins the scan chain. A one-cycle start pulse launches a fixed program. First comes a TAP reset prefix. Then five scans follow, alternating IR and DR, and each scan has its own length, data and final state. The program closes with a run of idle TCK periods. The block generates TCK by dividing the system clock. It follows the TAP state with its own model of the TAP controller, and it uses that model to pick the shortest TMS route into each shift state.

The interface is control only. There is no data stream in either direction, so no valid/ready handshake is involved. `start` is a level sampled on the clock and is acted on only while the block is idle. `busy` covers the whole program. `done` pulses once when the program ends. TDO is an input only and never influences the outputs.

Top module: `jrc_init_seq`

## Requirements
- R1: After reset `busy`, `done` and `tck` are low, and `tck` stays low whenever `busy` is low.
- R2: TCK has period `TCK_DIV` system clocks (default 4) and is low for the first `TCK_DIV/2` clocks of each period. TMS and TDI change only while TCK is low.
- R3: The program opens with five TCK periods with TMS high followed by one with TMS low. This leaves the TAP in Test-Logic-Reset after the fifth rising edge and in Run-Test/Idle after the sixth, whatever state it started in.
- R4: Five scans follow, in this order: IR 6 bits 0x07, DR 8 bits 0x89, IR 6 bits 0x02, DR 32 bits 0xA3002108 (route port `ROUTE_PORT`=3 placed in bits 27:24), IR 6 bits all ones. Data goes out LSB first, and TMS is high only on the last bit, which moves the TAP to Exit1.
- R5: Each scan reaches its shift state over the shortest TMS path from the state in which the TAP sits. For the five scans these paths are 4, 5, 6, 5 and 6 rising edges long.
- R6: Scans one to four stop in Pause-IR or Pause-DR, matching the register just shifted. The last scan leaves Exit1-IR through Update-IR into Run-Test/Idle.
- R7: After the last scan, TMS stays low for `IDLE_CLKS` (default 10) TCK periods in Run-Test/Idle. The TAP ends the program in Run-Test/Idle.
- R8: `busy` is high from the clock after an accepted start for exactly 106 × `TCK_DIV` clocks with defaults, and it falls in the cycle in which `done` is high for a single clock.
- R9: A start pulse seen while `busy` is high has no effect. Program length, TMS/TDI content and the number of `done` pulses stay unchanged.
- R10: TDO held at 0, held at 1 or toggling produces the identical TCK/TMS/TDI sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches the program when idle |
| tdo | input | 1 | Test data from the chain, ignored |
| busy | output | 1 | Program in progress |
| done | output | 1 | One-clock pulse at program end |
| tck | output | 1 | Divided test clock |
| tms | output | 1 | Test mode select, changes while TCK is low |
| tdi | output | 1 | Test data to the chain, LSB first |

## Verification
The situation hardest to reach from the ports is a target TAP that begins in an arbitrary state, because the block never observes the real TAP. The bench runs its own TAP follower, driven only by the TCK/TMS/TDI pins, and starts it in each of the sixteen states in turn. In every run it checks that the reset prefix converges and that every later path, shift and final state matches. Odd runs insert a second start pulse deep inside the program. The runs also rotate TDO between constant low, constant high and toggling.

// File: rtl/jrc_pkg.sv
package jrc_pkg;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_st_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RST, PH_NAV, PH_SHIFT, PH_END, PH_WAIT
  } ph_e;

  typedef struct packed {
    logic        is_ir;
    logic        end_idle;
    logic [5:0]  len;
    logic [31:0] data;
  } scan_step_t;

  typedef struct packed {
    logic [2:0] len;
    logic [5:0] bits;
  } nav_path_t;

  localparam int STEP_CNT  = 5;
  localparam int RST_BITS  = 6;
  localparam int RST_ONES  = 5;

  function automatic tap_st_e tap_next(tap_st_e s, logic m);
    case (s)
      TS_RESET:  return m ? TS_RESET  : TS_IDLE;
      TS_IDLE:   return m ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: return m ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: return m ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  return m ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: return m ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: return m ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: return m ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR: return m ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: return m ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: return m ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  return m ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: return m ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: return m ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: return m ? TS_UPD_IR : TS_SH_IR;
      default:   return m ? TS_SEL_DR : TS_IDLE;
    endcase
  endfunction

  // Fixed router program; the route port lands in bits 27:24 of the 32-bit word.
  function automatic scan_step_t step_info(logic [2:0] idx, logic [3:0] port);
    scan_step_t s;
    s = '0;
    case (idx)
      3'd0: begin s.is_ir = 1'b1; s.len = 6'd6;  s.data = 32'h0000_0007; end
      3'd1: begin s.is_ir = 1'b0; s.len = 6'd8;  s.data = 32'h0000_0089; end
      3'd2: begin s.is_ir = 1'b1; s.len = 6'd6;  s.data = 32'h0000_0002; end
      3'd3: begin s.is_ir = 1'b0; s.len = 6'd32; s.data = {4'hA, port, 24'h00_2108}; end
      default: begin s.is_ir = 1'b1; s.end_idle = 1'b1; s.len = 6'd6; s.data = 32'h0000_003F; end
    endcase
    return s;
  endfunction

  // Shortest TMS route into a shift state, bit 0 sent first.
  function automatic nav_path_t nav_path(tap_st_e from, logic to_ir);
    nav_path_t p;
    case (from)
      TS_RESET:  p = to_ir ? '{3'd5, 6'b000110} : '{3'd4, 6'b000010};
      TS_PAU_IR: p = to_ir ? '{3'd2, 6'b000001} : '{3'd5, 6'b000111};
      TS_PAU_DR: p = to_ir ? '{3'd6, 6'b001111} : '{3'd2, 6'b000001};
      default:   p = to_ir ? '{3'd4, 6'b000011} : '{3'd3, 6'b000001};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/jrc_tck_div.sv
module jrc_tck_div #(
  parameter int TCK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tck,
  output logic rise,
  output logic adv
);
  localparam int HALF = TCK_DIV / 2;
  localparam int CW   = (TCK_DIV > 2) ? $clog2(TCK_DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (!run || adv) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tck  = run && (cnt >= CW'(HALF));
  assign rise = run && (cnt == CW'(HALF - 1));
  assign adv  = run && (cnt == CW'(TCK_DIV - 1));
endmodule

// File: rtl/jrc_tap_model.sv
module jrc_tap_model
  import jrc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rise,
  input  logic    tms,
  output tap_st_e state
);
  always_ff @(posedge clk) begin
    if (!rst_n)    state <= TS_RESET;
    else if (rise) state <= tap_next(state, tms);
  end
endmodule

// File: rtl/jrc_scan_seq.sv
module jrc_scan_seq
  import jrc_pkg::*;
#(
  parameter int ROUTE_PORT = 3,
  parameter int IDLE_CLKS  = 10
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    adv,
  input  tap_st_e tap_state,
  output logic    busy,
  output logic    done,
  output logic    tms,
  output logic    tdi
);
  localparam int MAXL = (IDLE_CLKS > 32) ? IDLE_CLKS : 32;
  localparam int IW   = $clog2(MAXL + 1);
  localparam logic [2:0] LAST_STEP = 3'(STEP_CNT - 1);

  ph_e        phase;
  logic [IW-1:0] idx;
  logic [2:0] step;
  tap_st_e    origin;

  scan_step_t    cur;
  nav_path_t     path;
  logic [IW-1:0] plen;
  logic          last;

  always_comb begin
    cur  = step_info(step, 4'(ROUTE_PORT));
    path = nav_path(origin, cur.is_ir);
    case (phase)
      PH_RST:   plen = IW'(RST_BITS);
      PH_NAV:   plen = IW'(path.len);
      PH_SHIFT: plen = IW'(cur.len);
      PH_END:   plen = cur.end_idle ? IW'(2) : IW'(1);
      PH_WAIT:  plen = IW'(IDLE_CLKS);
      default:  plen = IW'(1);
    endcase
    last = (idx == plen - 1'b1);
  end

  always_comb begin
    tms = 1'b0;
    tdi = 1'b0;
    case (phase)
      PH_RST:   tms = (idx < IW'(RST_ONES));
      PH_NAV:   tms = path.bits[idx[2:0]];
      PH_SHIFT: begin tms = last; tdi = cur.data[idx[4:0]]; end
      PH_END:   tms = cur.end_idle && (idx == '0);
      default:  tms = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      idx    <= '0;
      step   <= '0;
      origin <= TS_IDLE;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start) begin
          phase <= PH_RST;
          idx   <= '0;
          step  <= '0;
          busy  <= 1'b1;
        end
      end else if (adv) begin
        if (!last) begin
          idx <= idx + 1'b1;
        end else begin
          idx <= '0;
          case (phase)
            PH_RST: begin
              phase  <= PH_NAV;
              origin <= tap_state;
            end
            PH_NAV:   phase <= PH_SHIFT;
            PH_SHIFT: phase <= PH_END;
            PH_END: begin
              if (step == LAST_STEP) begin
                phase <= PH_WAIT;
              end else begin
                step   <= step + 1'b1;
                phase  <= PH_NAV;
                origin <= tap_state;
              end
            end
            default: begin
              phase <= PH_IDLE;
              busy  <= 1'b0;
              done  <= 1'b1;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/jrc_init_seq.sv
module jrc_init_seq
  import jrc_pkg::*;
#(
  parameter int TCK_DIV    = 4,
  parameter int ROUTE_PORT = 3,
  parameter int IDLE_CLKS  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tdo,
  output logic busy,
  output logic done,
  output logic tck,
  output logic tms,
  output logic tdi
);
  logic    rise;
  logic    adv;
  tap_st_e tap_q;
  logic    unused_tdo;

  assign unused_tdo = tdo;

  jrc_tck_div #(.TCK_DIV(TCK_DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tck  (tck),
    .rise (rise),
    .adv  (adv)
  );

  jrc_tap_model u_tap (
    .clk  (clk),
    .rst_n(rst_n),
    .rise (rise),
    .tms  (tms),
    .state(tap_q)
  );

  jrc_scan_seq #(.ROUTE_PORT(ROUTE_PORT), .IDLE_CLKS(IDLE_CLKS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .adv      (adv),
    .tap_state(tap_q),
    .busy     (busy),
    .done     (done),
    .tms      (tms),
    .tdi      (tdi)
  );
endmodule

// File: rtl/jrc_init_seq_chk.sv
module jrc_init_seq_chk
  import jrc_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    start,
  input logic    busy,
  input logic    done,
  input logic    tck,
  input logic    tms,
  input logic    tdi,
  input tap_st_e tap_state
);
  // R2: pins settle only while TCK is low
  a_r2_pins_move_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tms != $past(tms) || tdi != $past(tdi)) |-> !tck);

  // R1: TCK parked low outside a program
  a_r1_tck_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tck);

  // R8: done coincides with busy falling
  a_r8_done_closes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R8: done lasts one clock
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: the tracked TAP sits in Run-Test/Idle at the end
  a_r7_idle_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> tap_state == TS_IDLE);

  // R9: busy only rises after a start request
  a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind jrc_init_seq jrc_init_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .tck      (tck),
  .tms      (tms),
  .tdi      (tdi),
  .tap_state(tap_q)
);

// File: tb/jrc_init_seq_test.sv
`timescale 1ns/1ps
module jrc_init_seq_test;
  localparam int DIV    = 4;
  localparam int SLOTS  = 106;
  localparam int LIMIT  = 150000;

  localparam int TLR = 0, RTI = 1, SDR = 2, CDR = 3, SHDR = 4, E1DR = 5, PDR = 6, E2DR = 7,
                 UDR = 8, SIR = 9, CIR = 10, SHIR = 11, E1IR = 12, PIR = 13, E2IR = 14, UIR = 15;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, tdo;
  logic busy, done, tck, tms, tdi;

  jrc_init_seq #(.TCK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .tdo(tdo),
    .busy(busy), .done(done), .tck(tck), .tms(tms), .tdi(tdi)
  );

  int total = 0, bad = 0, cyc = 0;
  int tdo_mode = 0;

  function automatic int nxt(int s, logic m);
    case (s)
      TLR: return m ? TLR : RTI;   RTI: return m ? SDR : RTI;
      SDR: return m ? SIR : CDR;   CDR: return m ? E1DR : SHDR;
      SHDR: return m ? E1DR : SHDR; E1DR: return m ? UDR : PDR;
      PDR: return m ? E2DR : PDR;  E2DR: return m ? UDR : SHDR;
      UDR: return m ? SDR : RTI;   SIR: return m ? TLR : CIR;
      CIR: return m ? E1IR : SHIR; SHIR: return m ? E1IR : SHIR;
      E1IR: return m ? UIR : PIR;  PIR: return m ? E2IR : PIR;
      E2IR: return m ? UIR : SHIR; default: return m ? SDR : RTI;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bench-side TAP follower, driven only by the pins
  bit mon_on = 0;
  int st, rise_n, k, nav, shl, idle_n, r5_st, r6_st;
  int glitches, busy_clks, done_n;
  bit want_end;
  logic [63:0] shv;
  int sc_ir[5], sc_len[5], sc_nav[5], sc_end[5];
  logic [63:0] sc_val[5];
  logic p_tck = 0, p_tms = 0, p_tdi = 0;

  always @(negedge clk) begin
    int pre;
    cyc++;
    if (mon_on) begin
      if (busy) busy_clks++;
      if (done) done_n++;
      if (tck && (tms !== p_tms || tdi !== p_tdi)) glitches++;
      if (tck && !p_tck) begin
        pre = st;
        st  = nxt(pre, tms);
        rise_n++;
        if (rise_n == 5) r5_st = st;
        if (rise_n == 6) begin r6_st = st; nav = 0; end
        else if (rise_n > 6 && k < 5) begin
          if (want_end) begin
            sc_end[k] = st; k++; want_end = 0; nav = 0;
          end else if (pre == SHIR || pre == SHDR) begin
            if (shl < 64) shv[shl] = tdi;
            shl++;
            if (tms) begin
              sc_ir[k] = (pre == SHIR); sc_len[k] = shl; sc_val[k] = shv; want_end = 1;
            end
          end else begin
            nav++;
            if (st == SHIR || st == SHDR) begin sc_nav[k] = nav; shv = '0; shl = 0; end
          end
        end
        if (rise_n > 6 && k == 5 && pre == RTI && !tms) idle_n++;
      end
    end
    p_tck = tck; p_tms = tms; p_tdi = tdi;
  end

  initial begin
    forever begin
      @(negedge clk);
      if (tdo_mode == 2) tdo = ~tdo;
      else               tdo = tdo_mode[0];
    end
  end

  initial begin
    int exp_ir[5]  = '{1, 0, 1, 0, 1};
    int exp_len[5] = '{6, 8, 6, 32, 6};
    longint exp_val[5] = '{64'h07, 64'h89, 64'h02, 64'hA3002108, 64'h3F};
    int exp_nav[5] = '{4, 5, 6, 5, 6};          // shortest routes (R5)
    int exp_end[5] = '{PIR, PDR, PIR, PDR, UIR};
    rst_n = 0; start = 0; tdo = 0;
    repeat (5) @(negedge clk);
    chk(busy == 0 && done == 0 && tck == 0, "R1", "reset outputs", {busy, done, tck}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(tck == 0 && busy == 0, "R1", "idle tck", tck, 0);

    for (int r = 0; r < 16; r++) begin
      st = r; rise_n = 0; k = 0; nav = 0; shl = 0; idle_n = 0; want_end = 0; shv = '0;
      glitches = 0; busy_clks = 0; done_n = 0; r5_st = -1; r6_st = -1;
      for (int i = 0; i < 5; i++) begin sc_ir[i] = -1; sc_len[i] = -1; sc_nav[i] = -1; sc_end[i] = -1; sc_val[i] = '1; end
      tdo_mode = r % 3;
      mon_on = 1;
      start = 1; @(negedge clk); start = 0;
      if (r % 2 == 1) begin
        repeat (150) @(negedge clk);
        start = 1; @(negedge clk); start = 0;  // R9: must be ignored
      end
      while (done_n == 0 && cyc < LIMIT) @(negedge clk);
      if (done_n == 0) begin
        chk(0, "R8", "watchdog expired", cyc, LIMIT);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
      repeat (6) @(negedge clk);
      mon_on = 0;
      chk(r5_st == TLR, "R3", "state after 5 TMS-high", r5_st, TLR);
      chk(r6_st == RTI, "R3", "state after prefix", r6_st, RTI);
      for (int i = 0; i < 5; i++) begin
        chk(sc_ir[i] == exp_ir[i] && sc_len[i] == exp_len[i], "R4", "scan kind/length",
            sc_ir[i] * 100 + sc_len[i], exp_ir[i] * 100 + exp_len[i]);
        chk(sc_val[i] == 64'(exp_val[i]), "R4", "scan value", sc_val[i], exp_val[i]);
        chk(sc_nav[i] == exp_nav[i], "R5", "route length", sc_nav[i], exp_nav[i]);
        chk(sc_end[i] == exp_end[i], "R6", "state after exit1", sc_end[i], exp_end[i]);
      end
      chk(idle_n == 10, "R7", "idle periods", idle_n, 10);
      chk(st == RTI, "R7", "final state", st, RTI);
      chk(glitches == 0, "R2", "TMS/TDI moved while TCK high", glitches, 0);
      chk(busy_clks == SLOTS * DIV, "R8", "busy length", busy_clks, SLOTS * DIV);
      chk(done_n == 1, "R8", "done pulses", done_n, 1);
      if (r % 2 == 1)
        chk(busy_clks == SLOTS * DIV && done_n == 1, "R9", "restart while busy", busy_clks, SLOTS * DIV);
      chk(rise_n == SLOTS, "R10", "TCK periods with tdo mode", rise_n, SLOTS);
      chk(tck == 0 && busy == 0, "R1", "tck parked after run", tck, 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule